// File: doc/BRIEF.md
# Sector Protection Command Unlock

This block sits behind the byte deserialiser of a serial flash port and watches every chip-select frame for the command sequences that control sector protection. It keeps one protection byte per sector and a global software enable flag. It also samples a hardware write-protect pin through a debounce stage. From these it drives a per-sector write-inhibit vector, which the program and erase engines consult before they touch the array.

Protection state changes only when a frame ends with chip select rising. A frame is acted on only if its leading bytes match one full four-byte unlock sequence. A frame that is too short, carries a wrong byte, or runs past its expected length is discarded. A programming frame stages its data bytes and commits them at the end of the frame. If the frame stopped early, every sector it did not reach is marked unverified and treated as protected. A read frame returns the stored protection bytes one per received byte. The write-protect pin, once debounced and low, forces protection on and blocks the software disable.

Top module: `sector_prot_unlock`

## Requirements
- R1: After reset, prot_on_o is 0, inhibit_o and unverified_o are all zero, and tx_vld_o is 0. Every protection byte resets to RST_ENTRY (default FFh).
- R2: A frame of exactly the bytes 3Dh, 2Ah, 7Fh, A9h sets the software enable when chip select rises, so prot_on_o becomes 1.
- R3: A frame of exactly 3Dh, 2Ah, 7Fh, 9Ah clears the software enable at chip-select rise, provided the debounced write-protect is not asserted.
- R4: A frame that is short, has any mismatched byte, or has extra bytes after a four-byte enable or disable sequence leaves the enable unchanged. The enable never changes while chip select is low.
- R5: A frame starting 3Dh, 2Ah, 7Fh, FCh carries data bytes. The k-th data byte (k from 0) is the new protection byte of sector k. Nothing is committed before chip select rises.
- R6: If a programming frame ends after n data bytes with 0 < n < NUM_SECT, sectors n and above are flagged in unverified_o. A frame with all NUM_SECT bytes clears every flag. A frame with no data bytes changes nothing. Flags change only at chip-select rise.
- R7: Data bytes after the NUM_SECT-th byte of a programming frame are ignored.
- R8: inhibit_o[i] is 1 exactly when prot_on_o is 1 and sector i's protection byte is nonzero or its unverified flag is set.
- R9: While the debounced write-protect (wp_n_i low) is asserted, prot_on_o is 1 whatever the software enable holds.
- R10: A disable sequence received while the debounced write-protect is asserted has no effect. The enable is still set after the pin is released.
- R11: The debounced write-protect level changes only after the synchronised pin has shown the new level for FILT_CYC consecutive clocks. Shorter pulses are dropped.
- R12: A frame of 32h followed by three don't-care bytes raises tx_vld_o and shows sector 0's byte on tx_byte_o. Each further byte advances to the next sector, wrapping after the last. tx_vld_o falls one clock after chip select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, low during a frame, synchronous to clk |
| byte_vld_i | input | 1 | One-cycle strobe: byte_i holds a received byte |
| byte_i | input | 8 | Received serial byte |
| wp_n_i | input | 1 | Raw write-protect pin, active low |
| tx_vld_o | output | 1 | Protection byte on tx_byte_o is valid for shifting out |
| tx_byte_o | output | 8 | Protection byte of the currently addressed sector |
| prot_on_o | output | 1 | Protection in force (software enable or write-protect) |
| unverified_o | output | NUM_SECT | Sectors whose protection byte was not delivered |
| inhibit_o | output | NUM_SECT | Per-sector program/erase inhibit |

## Verification
The bench builds the block with NUM_SECT at 16 and FILT_CYC at 4. With these values a read frame can walk the full register and wrap back to sector 0, and a partial programming frame leaves a visible band of unverified sectors. The short filter lets the bench drop a two-clock pulse and watch a real level change within a dozen cycles. It can then assert write-protect around enable and disable frames and release it again cheaply.

// File: rtl/sp_pkg.sv
package sp_pkg;

  localparam int HDR_LEN = 4;

  localparam logic [7:0] PRE_B0   = 8'h3D;
  localparam logic [7:0] PRE_B1   = 8'h2A;
  localparam logic [7:0] PRE_B2   = 8'h7F;
  localparam logic [7:0] TAIL_EN  = 8'hA9;
  localparam logic [7:0] TAIL_DIS = 8'h9A;
  localparam logic [7:0] TAIL_PRG = 8'hFC;
  localparam logic [7:0] OP_RDREG = 8'h32;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_HDR,
    FR_READ,
    FR_EN,
    FR_DIS,
    FR_PROG,
    FR_BAD
  } frame_e;

endpackage

// File: rtl/sp_wp_filter.sv
module sp_wp_filter #(
  parameter int FILT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n_i,
  output logic wp_act_o
);

  localparam int CNTW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(FILT_CYC - 1);

  logic s1_q, s2_q;
  logic lvl_q, lvl_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (s2_q != lvl_q) begin
      if (cnt_q == CNT_LAST) begin
        lvl_d = s2_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      s1_q  <= wp_n_i;
      s2_q  <= s1_q;
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign wp_act_o = ~lvl_q;

endmodule

// File: rtl/sp_cmd_seq.sv
module sp_cmd_seq
  import sp_pkg::*;
#(
  parameter int NUM_SECT = 16,
  parameter int IW       = 4,
  parameter int NW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  output logic          act_en_o,
  output logic          act_dis_o,
  output logic          act_prog_o,
  output logic [NW-1:0] prog_cnt_o,
  output logic          stg_we_o,
  output logic [IW-1:0] stg_idx_o,
  output logic [7:0]    stg_data_o,
  output logic          rd_act_o,
  output logic [IW-1:0] rd_idx_o
);

  localparam int CW = $clog2(HDR_LEN + NUM_SECT + 2);
  localparam logic [CW-1:0] CNT_MAX  = CW'(HDR_LEN + NUM_SECT + 1);
  localparam logic [CW-1:0] CNT_HDR  = CW'(HDR_LEN);
  localparam logic [CW-1:0] CNT_LAST_HDR = CW'(HDR_LEN - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(HDR_LEN + NUM_SECT);
  localparam logic [IW-1:0] IDX_LAST = IW'(NUM_SECT - 1);

  logic          cs_q;
  frame_e        kind_q, kind_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rd_q, rd_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          cs_rise, take;
  logic [CW-1:0] data_cnt;

  assign cs_rise  = cs_n_i & ~cs_q;
  assign take     = byte_vld_i & ~cs_n_i;
  assign data_cnt = cnt_q - CNT_HDR;

  always_comb begin
    kind_d = kind_q;
    cnt_d  = cnt_q;
    rd_d   = rd_q;
    idx_d  = idx_q;
    if (cs_rise) begin
      kind_d = FR_IDLE;
      cnt_d  = '0;
      rd_d   = 1'b0;
      idx_d  = '0;
    end else if (take) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      unique case (kind_q)
        FR_IDLE: begin
          if (byte_i == PRE_B0)        kind_d = FR_HDR;
          else if (byte_i == OP_RDREG) kind_d = FR_READ;
          else                         kind_d = FR_BAD;
        end
        FR_HDR: begin
          if (cnt_q == CW'(1)) begin
            if (byte_i != PRE_B1) kind_d = FR_BAD;
          end else if (cnt_q == CW'(2)) begin
            if (byte_i != PRE_B2) kind_d = FR_BAD;
          end else begin
            if (byte_i == TAIL_EN)       kind_d = FR_EN;
            else if (byte_i == TAIL_DIS) kind_d = FR_DIS;
            else if (byte_i == TAIL_PRG) kind_d = FR_PROG;
            else                         kind_d = FR_BAD;
          end
        end
        FR_READ: begin
          if (cnt_q == CNT_LAST_HDR) begin
            rd_d  = 1'b1;
            idx_d = '0;
          end else if (rd_q) begin
            idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
          end
        end
        FR_EN, FR_DIS: kind_d = FR_BAD;
        FR_PROG:       kind_d = FR_PROG;
        default:       kind_d = FR_BAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      kind_q <= FR_IDLE;
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
    end else begin
      cs_q   <= cs_n_i;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      rd_q   <= rd_d;
      idx_q  <= idx_d;
    end
  end

  assign act_en_o   = cs_rise && (kind_q == FR_EN);
  assign act_dis_o  = cs_rise && (kind_q == FR_DIS);
  assign act_prog_o = cs_rise && (kind_q == FR_PROG) && (cnt_q != CNT_HDR);
  assign prog_cnt_o = (cnt_q >= CNT_FULL) ? NW'(NUM_SECT) : NW'(data_cnt);
  assign stg_we_o   = take && (kind_q == FR_PROG) && (cnt_q < CNT_FULL);
  assign stg_idx_o  = IW'(data_cnt);
  assign stg_data_o = byte_i;
  assign rd_act_o   = rd_q;
  assign rd_idx_o   = idx_q;

endmodule

// File: rtl/sp_prot_regs.sv
module sp_prot_regs #(
  parameter int         NUM_SECT  = 16,
  parameter int         IW        = 4,
  parameter int         NW        = 5,
  parameter logic [7:0] RST_ENTRY = 8'hFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                act_en_i,
  input  logic                act_dis_i,
  input  logic                act_prog_i,
  input  logic [NW-1:0]       prog_cnt_i,
  input  logic                stg_we_i,
  input  logic [IW-1:0]       stg_idx_i,
  input  logic [7:0]          stg_data_i,
  input  logic                wp_act_i,
  input  logic [IW-1:0]       rd_idx_i,
  output logic                prot_en_o,
  output logic                prot_on_o,
  output logic [NUM_SECT-1:0] inhibit_o,
  output logic [NUM_SECT-1:0] unverified_o,
  output logic [7:0]          rd_byte_o
);

  logic [7:0]          ent_q [NUM_SECT];
  logic [7:0]          ent_d [NUM_SECT];
  logic [7:0]          stg_q [NUM_SECT];
  logic [7:0]          stg_d [NUM_SECT];
  logic [NUM_SECT-1:0] unv_q, unv_d;
  logic                en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (act_en_i)                   en_d = 1'b1;
    else if (act_dis_i && !wp_act_i) en_d = 1'b0;
  end

  always_comb begin
    stg_d = stg_q;
    if (stg_we_i) stg_d[stg_idx_i] = stg_data_i;
  end

  always_comb begin
    ent_d = ent_q;
    unv_d = unv_q;
    if (act_prog_i) begin
      for (int i = 0; i < NUM_SECT; i++) begin
        if (NW'(i) < prog_cnt_i) begin
          ent_d[i] = stg_q[i];
          unv_d[i] = 1'b0;
        end else begin
          unv_d[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      unv_q <= '0;
      for (int i = 0; i < NUM_SECT; i++) begin
        ent_q[i] <= RST_ENTRY;
        stg_q[i] <= 8'h00;
      end
    end else begin
      en_q  <= en_d;
      unv_q <= unv_d;
      ent_q <= ent_d;
      if (stg_we_i) stg_q <= stg_d;
    end
  end

  assign prot_en_o    = en_q;
  assign prot_on_o    = en_q | wp_act_i;
  assign unverified_o = unv_q;
  assign rd_byte_o    = ent_q[rd_idx_i];

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
    assign inhibit_o[g] = prot_on_o & ((ent_q[g] != 8'h00) | unv_q[g]);
  end

endmodule

// File: rtl/sector_prot_unlock.sv
module sector_prot_unlock #(
  parameter int         NUM_SECT  = 16,
  parameter int         FILT_CYC  = 8,
  parameter logic [7:0] RST_ENTRY = 8'hFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n_i,
  input  logic                byte_vld_i,
  input  logic [7:0]          byte_i,
  input  logic                wp_n_i,
  output logic                tx_vld_o,
  output logic [7:0]          tx_byte_o,
  output logic                prot_on_o,
  output logic [NUM_SECT-1:0] unverified_o,
  output logic [NUM_SECT-1:0] inhibit_o
);

  localparam int IW = $clog2(NUM_SECT);
  localparam int NW = $clog2(NUM_SECT + 1);

  logic          wp_act_w;
  logic          act_en_w, act_dis_w, act_prog_w;
  logic [NW-1:0] prog_cnt_w;
  logic          stg_we_w;
  logic [IW-1:0] stg_idx_w;
  logic [7:0]    stg_data_w;
  logic [IW-1:0] rd_idx_w;
  logic          prot_en_w;

  sp_wp_filter #(.FILT_CYC(FILT_CYC)) u_wpf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n_i   (wp_n_i),
    .wp_act_o (wp_act_w)
  );

  sp_cmd_seq #(.NUM_SECT(NUM_SECT), .IW(IW), .NW(NW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (cs_n_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .act_en_o   (act_en_w),
    .act_dis_o  (act_dis_w),
    .act_prog_o (act_prog_w),
    .prog_cnt_o (prog_cnt_w),
    .stg_we_o   (stg_we_w),
    .stg_idx_o  (stg_idx_w),
    .stg_data_o (stg_data_w),
    .rd_act_o   (tx_vld_o),
    .rd_idx_o   (rd_idx_w)
  );

  sp_prot_regs #(.NUM_SECT(NUM_SECT), .IW(IW), .NW(NW), .RST_ENTRY(RST_ENTRY)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .act_en_i     (act_en_w),
    .act_dis_i    (act_dis_w),
    .act_prog_i   (act_prog_w),
    .prog_cnt_i   (prog_cnt_w),
    .stg_we_i     (stg_we_w),
    .stg_idx_i    (stg_idx_w),
    .stg_data_i   (stg_data_w),
    .wp_act_i     (wp_act_w),
    .rd_idx_i     (rd_idx_w),
    .prot_en_o    (prot_en_w),
    .prot_on_o    (prot_on_o),
    .inhibit_o    (inhibit_o),
    .unverified_o (unverified_o),
    .rd_byte_o    (tx_byte_o)
  );

endmodule

// File: rtl/sp_prot_checker.sv
module sp_prot_checker #(
  parameter int NUM_SECT = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_n_i,
  input logic                prot_on_o,
  input logic [NUM_SECT-1:0] inhibit_o,
  input logic [NUM_SECT-1:0] unverified_o,
  input logic                tx_vld_o,
  input logic                prot_en,
  input logic                wp_act
);

  assert_off_no_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_on_o |-> (inhibit_o == '0));

  assert_unverified_inhibits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prot_on_o |-> ((unverified_o & ~inhibit_o) == '0));

  assert_flags_hold_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_i |=> $stable(unverified_o));

  assert_enable_hold_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_i |=> $stable(prot_en));

  assert_wp_blocks_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_act && prot_en) |=> prot_en);

  assert_tx_drops_after_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_i) |=> !tx_vld_o);

endmodule

bind sector_prot_unlock sp_prot_checker #(.NUM_SECT(NUM_SECT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n_i       (cs_n_i),
  .prot_on_o    (prot_on_o),
  .inhibit_o    (inhibit_o),
  .unverified_o (unverified_o),
  .tx_vld_o     (tx_vld_o),
  .prot_en      (prot_en_w),
  .wp_act       (wp_act_w)
);

// File: tb/sector_prot_unlock_bench.sv
`timescale 1ns/1ps
module sector_prot_unlock_bench;

  localparam int NS = 16;
  localparam int FC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          bvld = 1'b0;
  logic [7:0]    bdat = 8'h00;
  logic          wp_n = 1'b1;
  logic          tx_vld;
  logic [7:0]    tx_byte;
  logic          prot_on;
  logic [NS-1:0] unver;
  logic [NS-1:0] inhib;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  sector_prot_unlock #(.NUM_SECT(NS), .FILT_CYC(FC), .RST_ENTRY(8'hFF)) u_sector_prot_unlock (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n_i       (cs_n),
    .byte_vld_i   (bvld),
    .byte_i       (bdat),
    .wp_n_i       (wp_n),
    .tx_vld_o     (tx_vld),
    .tx_byte_o    (tx_byte),
    .prot_on_o    (prot_on),
    .unverified_o (unver),
    .inhibit_o    (inhib)
  );

  // {expected prot_on, length, byte0, byte1, byte2, byte3}
  localparam logic [40:0] VEC [8] = '{
    {1'b1, 8'd4, 8'h3D, 8'h2A, 8'h7F, 8'hA9},  // R2 enable
    {1'b0, 8'd4, 8'h3D, 8'h2A, 8'h7F, 8'h9A},  // R3 disable
    {1'b0, 8'd4, 8'h3D, 8'h2B, 8'h7F, 8'hA9},  // R4 wrong second byte
    {1'b0, 8'd3, 8'h3D, 8'h2A, 8'h7F, 8'h00},  // R4 short frame
    {1'b1, 8'd4, 8'h3D, 8'h2A, 8'h7F, 8'hA9},  // R2 enable again
    {1'b1, 8'd4, 8'h3D, 8'h2A, 8'h7F, 8'h9B},  // R4 wrong tail
    {1'b1, 8'd4, 8'h32, 8'h2A, 8'h7F, 8'hA9},  // R4 read opcode, no effect
    {1'b0, 8'd4, 8'h3D, 8'h2A, 8'h7F, 8'h9A}   // R3 disable
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    bdat = b;
    bvld = 1'b1;
    @(negedge clk);
    bvld = 1'b0;
  endtask

  task automatic cs_lo();
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic cs_hi();
    @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic hdr(input logic [7:0] tail);
    send(8'h3D); send(8'h2A); send(8'h7F); send(tail);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [40:0] v;
    int bad;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    chk("R1 prot_on", 32'(prot_on), 32'd0);
    chk("R1 inhibit", 32'(inhib), 32'd0);
    chk("R1 unverified", 32'(unver), 32'd0);
    chk("R1 tx_vld", 32'(tx_vld), 32'd0);

    // vector table: enable/disable/mismatch frames (R2 R3 R4 R8)
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      cs_lo();
      for (int k = 0; k < int'(v[39:32]); k++) send(v[31 - 8*k -: 8]);
      cs_hi();
      chk("R2/R3/R4 table prot_on", 32'(prot_on), 32'(v[40]));
      chk("R8 table inhibit", 32'(inhib), v[40] ? 32'h0000FFFF : 32'd0);
    end

    // R4 extra byte after enable sequence
    cs_lo(); hdr(8'hA9); send(8'h00); cs_hi();
    chk("R4 extra byte", 32'(prot_on), 32'd0);

    cs_lo(); hdr(8'hA9); cs_hi();
    chk("R2 enable", 32'(prot_on), 32'd1);

    // R5 full program, commit only at frame end
    cs_lo(); hdr(8'hFC);
    for (int k = 0; k < NS; k++) send((k % 2 == 0) ? 8'hFF : 8'h00);
    chk("R5 no commit mid-frame", 32'(inhib), 32'h0000FFFF);
    cs_hi();
    chk("R5 committed pattern", 32'(inhib), 32'h00005555);
    chk("R6 full clears flags", 32'(unver), 32'd0);

    // R12 read back with wrap
    cs_lo();
    send(8'h32); send(8'h00); send(8'h00);
    chk("R12 tx idle before third dummy", 32'(tx_vld), 32'd0);
    send(8'h00);
    chk("R12 tx_vld", 32'(tx_vld), 32'd1);
    chk("R12 sector 0", 32'(tx_byte), 32'hFF);
    bad = 0;
    for (int k = 1; k < NS; k++) begin
      send(8'h00);
      if (tx_byte !== ((k % 2 == 0) ? 8'hFF : 8'h00)) bad++;
    end
    chk("R12 sectors 1..15 mismatches", 32'(bad), 32'd0);
    send(8'h00);
    chk("R12 wrap to sector 0", 32'(tx_byte), 32'hFF);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    chk("R12 tx_vld drops", 32'(tx_vld), 32'd0);
    wait_cyc(2);

    // R6 partial program: five bytes of 00
    cs_lo(); hdr(8'hFC);
    for (int k = 0; k < 5; k++) send(8'h00);
    cs_hi();
    chk("R6 partial unverified", 32'(unver), 32'h0000FFE0);
    chk("R6 partial inhibit", 32'(inhib), 32'h0000FFE0);

    // R6 header only, no data
    cs_lo(); hdr(8'hFC); cs_hi();
    chk("R6 empty program", 32'(unver), 32'h0000FFE0);

    // R7 surplus byte ignored
    cs_lo(); hdr(8'hFC);
    for (int k = 0; k < NS; k++) send(8'h00);
    send(8'hFF);
    cs_hi();
    chk("R7 surplus inhibit", 32'(inhib), 32'd0);
    chk("R7 surplus flags", 32'(unver), 32'd0);

    // all sectors protected, then software disable
    cs_lo(); hdr(8'hFC);
    for (int k = 0; k < NS; k++) send(8'hFF);
    cs_hi();
    chk("R8 all protected", 32'(inhib), 32'h0000FFFF);
    cs_lo(); hdr(8'h9A); cs_hi();
    chk("R3 disable", 32'(prot_on), 32'd0);
    chk("R8 off no inhibit", 32'(inhib), 32'd0);

    // R11 short glitch dropped
    @(negedge clk); wp_n = 1'b0;
    wait_cyc(2);
    wp_n = 1'b1;
    wait_cyc(10);
    chk("R11 glitch dropped", 32'(prot_on), 32'd0);

    // R11 level change needs FC clocks, R9 forced on
    @(negedge clk); wp_n = 1'b0;
    wait_cyc(3);
    chk("R11 not yet filtered", 32'(prot_on), 32'd0);
    wait_cyc(8);
    chk("R9 wp forces on", 32'(prot_on), 32'd1);
    chk("R9 wp inhibit", 32'(inhib), 32'h0000FFFF);

    // R10 disable ignored under write-protect
    cs_lo(); hdr(8'hA9); cs_hi();
    cs_lo(); hdr(8'h9A); cs_hi();
    @(negedge clk); wp_n = 1'b1;
    wait_cyc(12);
    chk("R10 enable survives", 32'(prot_on), 32'd1);
    cs_lo(); hdr(8'h9A); cs_hi();
    chk("R3 disable after release", 32'(prot_on), 32'd0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule